// File: doc/BRIEF.md
# Rotated Lorenz Euler-Step Datapath

This block advances a three-variable Lorenz chaotic oscillator by one forward-Euler step per enabled clock cycle. The step is evaluated in a coordinate frame turned by a fixed angle, chosen at elaboration from 0, -45 or -90 degrees. All next-state arithmetic is combinational. A single feedback register holds the state words `u`, `v` and `w`, so an update is visible one clock edge after it is requested.

The equation constants are a = 10, b = 28 and c = 8/3, and the step size is h = 0.01. Every state word is a signed 64-bit fixed-point value with 40 fraction bits. Every multiply by a constant is an approximation built from shifted copies of the operand and a final arithmetic right shift. The two state-by-state products in each step use true multipliers. Each product is formed at 128 bits and then realigned to the state format.

Typical use: a waveform source or a pseudo-chaotic sequence generator that needs a new sample on each cycle in which `step_en_i` is high.

Top module: `lorenz_rot_step`

## Requirements
- R1: While `rst_ni` is low, and immediately when it falls, the outputs equal the parameters `U_INIT`, `V_INIT` and `W_INIT`. Values are signed 64-bit with 40 fraction bits, so 1.0 is 2^40.
- R2: At a rising edge where `step_en_i` is low, `u_o`, `v_o` and `w_o` keep their values.
- R3: With `ROT_DEG`=0, the state is updated as follows. The products are P(a,b) = (a*b at 128 bits) >>> 40, keeping the low 64 bits. The constant multiplies are kH(x) = (x*41) >>> 12, kHA(x) = (x*205) >>> 11 and kHC(x) = (x*109) >>> 12. The updates are u += kHA(v-u), v += kH(P(u, 28-w) - v) and w += kH(P(u,v)) - kHC(w).
- R4: With `ROT_DEG`=-45, the frame terms are T1 = kR(u-v) and T2 = kR(u+v), with kR(x) = (x*181) >>> 8. Let X = T2-T1 and Y = P(T1, 28-w) - T2. The updates are u += kA(X) + kB(Y), v += kB(Y) - kA(X) and w += kH(P(T1,T2)) - kHC(w). Here kA(x) = (x*291) >>> 12 and kB(x) = (x*29) >>> 12.
- R5: With `ROT_DEG`=-90, the frame terms are T1 = -v and T2 = u. The updates are u += kH(P(T1, 28-w) - T2), v -= kHA(u+v) and w += kH(P(T1,T2)) - kHC(w).
- R6: A product whose sign is negative is truncated by an arithmetic shift, which rounds toward minus infinity, and not by a shift that rounds toward zero.
- R7: Each rising edge with `step_en_i` high and `rst_ni` high applies exactly one update, and the result appears at the outputs after that edge.
- R8: A state with u = v = 0 keeps u and v at 0 in every frame. For w > 0, w never grows in that state.
- R9: Along trajectories that start near the attractor, the high bits of each 128-bit product above the state range are a pure sign extension, and every state word stays within +/-128.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; loads the initial state |
| step_en_i | input | 1 | Apply one Euler step at this edge |
| u_o | output | 64 | State word u, signed, 40 fraction bits |
| v_o | output | 64 | State word v, signed, 40 fraction bits |
| w_o | output | 64 | State word w, signed, 40 fraction bits |

## Verification
Because the system is chaotic, a single wrong bit in any shift-add constant, any frame term or any product truncation grows quickly into a visible divergence. The error first appears as a difference of a few least-significant bits at the output on the first edge that uses the faulty path. Within a few hundred steps it becomes a gross mismatch. The bench therefore compares all three words bit-exactly against its own model on every cycle, for each frame angle. This places a fault at the first step where it acts. Hold and reset faults show up on the very next edge as a changed word or a non-initial word.

// File: rtl/lorenz_rot_pkg.sv
package lorenz_rot_pkg;
  localparam int STATE_W = 64;
  localparam int FRAC_W  = 40;
  localparam int PROD_W  = 2 * STATE_W;

  typedef logic signed [STATE_W-1:0] q_t;
  typedef logic signed [PROD_W-1:0]  prod_t;

  localparam q_t B_Q = q_t'(28) <<< FRAC_W;

  // h = 0.01 ~ 41/4096
  function automatic q_t k_h(q_t x);
    return ((x <<< 5) + (x <<< 3) + x) >>> 12;
  endfunction

  // h*a = 0.1 ~ 205/2048
  function automatic q_t k_ha(q_t x);
    return ((x <<< 7) + (x <<< 6) + (x <<< 3) + (x <<< 2) + x) >>> 11;
  endfunction

  // h*c = 0.02667 ~ 109/4096
  function automatic q_t k_hc(q_t x);
    return ((x <<< 6) + (x <<< 5) + (x <<< 3) + (x <<< 2) + x) >>> 12;
  endfunction

  // cos45 ~ 181/256
  function automatic q_t k_rot(q_t x);
    return ((x <<< 7) + (x <<< 5) + (x <<< 4) + (x <<< 2) + x) >>> 8;
  endfunction

  // h*a*cos45 ~ 291/4096
  function automatic q_t k_hac(q_t x);
    return ((x <<< 8) + (x <<< 5) + (x <<< 1) + x) >>> 12;
  endfunction

  // h*cos45 ~ 29/4096
  function automatic q_t k_hr(q_t x);
    return ((x <<< 4) + (x <<< 3) + (x <<< 2) + x) >>> 12;
  endfunction

  function automatic prod_t mul_full(q_t a, q_t b);
    return prod_t'(a) * prod_t'(b);
  endfunction

  // realign a full product to the state format
  function automatic q_t trunc_q(prod_t p);
    prod_t s;
    s = p >>> FRAC_W;
    return s[STATE_W-1:0];
  endfunction
endpackage

// File: rtl/lorenz_frame.sv
module lorenz_frame
  import lorenz_rot_pkg::*;
#(
  parameter int ROT_DEG = 0
) (
  input  q_t u_i,
  input  q_t v_i,
  output q_t t1_o,
  output q_t t2_o
);
  generate
    if (ROT_DEG == 0) begin : g_rot0
      assign t1_o = u_i;
      assign t2_o = v_i;
    end else if (ROT_DEG == -45) begin : g_rot45
      assign t1_o = k_rot(u_i - v_i);
      assign t2_o = k_rot(u_i + v_i);
    end else begin : g_rot90
      assign t1_o = -v_i;
      assign t2_o = u_i;
    end
  endgenerate
endmodule

// File: rtl/lorenz_next.sv
module lorenz_next
  import lorenz_rot_pkg::*;
#(
  parameter int ROT_DEG = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  q_t   u_i,
  input  q_t   v_i,
  input  q_t   w_i,
  input  q_t   t1_i,
  input  q_t   t2_i,
  output q_t   u_o,
  output q_t   v_o,
  output q_t   w_o
);
  localparam int HI_LSB = FRAC_W + STATE_W - 1;
  localparam int HI_W   = PROD_W - HI_LSB;

  prod_t prod_y, prod_z;
  q_t    dx, dy, dz;

  assign prod_y = mul_full(t1_i, B_Q - w_i);
  assign prod_z = mul_full(t1_i, t2_i);
  assign dx     = t2_i - t1_i;
  assign dy     = trunc_q(prod_y) - t2_i;
  assign dz     = trunc_q(prod_z);
  assign w_o    = w_i + k_h(dz) - k_hc(w_i);

  generate
    if (ROT_DEG == 0) begin : g_out0
      assign u_o = u_i + k_ha(dx);
      assign v_o = v_i + k_h(dy);
    end else if (ROT_DEG == -45) begin : g_out45
      assign u_o = u_i + k_hac(dx) + k_hr(dy);
      assign v_o = v_i + k_hr(dy) - k_hac(dx);
    end else begin : g_out90
      assign u_o = u_i + k_h(dy);
      assign v_o = v_i - k_ha(dx);
    end
  endgenerate

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_y[PROD_W-1:HI_LSB] == '0) || (prod_y[PROD_W-1:HI_LSB] == {HI_W{1'b1}}));
  assert_no_overflow_prod_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_z[PROD_W-1:HI_LSB] == '0) || (prod_z[PROD_W-1:HI_LSB] == {HI_W{1'b1}}));
  assert_origin_fixed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u_i == '0 && v_i == '0) |-> (u_o == '0 && v_o == '0));
  assert_w_decay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u_i == '0 && v_i == '0 && w_i > 0) |-> (w_o <= w_i));
endmodule

// File: rtl/lorenz_rot_step.sv
module lorenz_rot_step
  import lorenz_rot_pkg::*;
#(
  parameter int ROT_DEG = 0,
  parameter q_t U_INIT  = q_t'(1) <<< FRAC_W,
  parameter q_t V_INIT  = q_t'(1) <<< FRAC_W,
  parameter q_t W_INIT  = q_t'(1) <<< FRAC_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      step_en_i,
  output logic signed [STATE_W-1:0] u_o,
  output logic signed [STATE_W-1:0] v_o,
  output logic signed [STATE_W-1:0] w_o
);
  q_t u_q, v_q, w_q;
  q_t t1, t2;
  q_t u_d, v_d, w_d;

  lorenz_frame #(.ROT_DEG(ROT_DEG)) u_frame (
    .u_i(u_q), .v_i(v_q), .t1_o(t1), .t2_o(t2)
  );

  lorenz_next #(.ROT_DEG(ROT_DEG)) u_next (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .u_i(u_q), .v_i(v_q), .w_i(w_q), .t1_i(t1), .t2_i(t2),
    .u_o(u_d), .v_o(v_d), .w_o(w_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      u_q <= U_INIT;
      v_q <= V_INIT;
      w_q <= W_INIT;
    end else if (step_en_i) begin
      u_q <= u_d;
      v_q <= v_d;
      w_q <= w_d;
    end
  end

  assign u_o = u_q;
  assign v_o = v_q;
  assign w_o = w_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> ($stable(u_q) && $stable(v_q) && $stable(w_q)));
endmodule

// File: tb/lorenz_rot_step_tb.sv
module lorenz_rot_step_tb;
  localparam int FR = 40;
  localparam int NI = 4;
  typedef logic signed [63:0] q_t;
  localparam q_t ONE = q_t'(1) <<< FR;
  localparam q_t B28 = q_t'(28) <<< FR;

  localparam int ANG [NI] = '{0, -45, -90, -45};
  localparam q_t IU  [NI] = '{ONE, ONE, 2 * ONE, 0};
  localparam q_t IV  [NI] = '{ONE, 2 * ONE, ONE, 0};
  localparam q_t IW  [NI] = '{ONE, 3 * ONE, ONE, 20 * ONE};

  // stimulus table: enable level and cycle count
  localparam int VEC_N = 12;
  localparam bit VEC_EN  [VEC_N] = '{1, 0, 1, 1, 0, 1, 0, 1, 1, 0, 1, 1};
  localparam int VEC_LEN [VEC_N] = '{1, 3, 40, 200, 5, 700, 1, 2, 300, 4, 600, 150};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic step_en = 1'b0;
  q_t du [NI];
  q_t dv [NI];
  q_t dw [NI];
  q_t mu [NI];
  q_t mv [NI];
  q_t mw [NI];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lorenz_rot_step #(.ROT_DEG(0), .U_INIT(IU[0]), .V_INIT(IV[0]), .W_INIT(IW[0])) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .step_en_i(step_en), .u_o(du[0]), .v_o(dv[0]), .w_o(dw[0]));
  lorenz_rot_step #(.ROT_DEG(-45), .U_INIT(IU[1]), .V_INIT(IV[1]), .W_INIT(IW[1])) u_dut_45 (
    .clk_i(clk), .rst_ni(rst_ni), .step_en_i(step_en), .u_o(du[1]), .v_o(dv[1]), .w_o(dw[1]));
  lorenz_rot_step #(.ROT_DEG(-90), .U_INIT(IU[2]), .V_INIT(IV[2]), .W_INIT(IW[2])) u_dut_90 (
    .clk_i(clk), .rst_ni(rst_ni), .step_en_i(step_en), .u_o(du[2]), .v_o(dv[2]), .w_o(dw[2]));
  lorenz_rot_step #(.ROT_DEG(-45), .U_INIT(IU[3]), .V_INIT(IV[3]), .W_INIT(IW[3])) u_dut_org (
    .clk_i(clk), .rst_ni(rst_ni), .step_en_i(step_en), .u_o(du[3]), .v_o(dv[3]), .w_o(dw[3]));

  function automatic q_t cmul(q_t x, int num, int sh);
    q_t acc = 0;
    for (int i = 0; i < 16; i++) if (num[i]) acc += x <<< i;
    return acc >>> sh;
  endfunction

  function automatic q_t pmul(q_t a, q_t b);
    logic signed [127:0] p;
    p = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
    p = p >>> FR;
    return p[63:0];
  endfunction

  task automatic model_step(int k);
    q_t u, v, w, t1, t2, x, y;
    u = mu[k]; v = mv[k]; w = mw[k];
    case (ANG[k])
      0:       begin t1 = u; t2 = v; end
      -45:     begin t1 = cmul(u - v, 181, 8); t2 = cmul(u + v, 181, 8); end
      default: begin t1 = -v; t2 = u; end
    endcase
    x = t2 - t1;
    y = pmul(t1, B28 - w) - t2;
    mw[k] = w + cmul(pmul(t1, t2), 41, 12) - cmul(w, 109, 12);
    case (ANG[k])
      0:       begin mu[k] = u + cmul(x, 205, 11); mv[k] = v + cmul(y, 41, 12); end
      -45:     begin mu[k] = u + cmul(x, 291, 12) + cmul(y, 29, 12);
                     mv[k] = v + cmul(y, 29, 12) - cmul(x, 291, 12); end
      default: begin mu[k] = u + cmul(y, 41, 12); mv[k] = v - cmul(x, 205, 11); end
    endcase
  endtask

  task automatic model_reset();
    for (int k = 0; k < NI; k++) begin mu[k] = IU[k]; mv[k] = IV[k]; mw[k] = IW[k]; end
  endtask

  task automatic chk(string tag, q_t got, q_t exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic string tag_of(int k, bit en);
    if (!en) return "R2 hold";
    case (k)
      0: return "R3 rot0";
      1: return "R4 rot45";
      2: return "R5 rot90";
      default: return "R8 origin";
    endcase
  endfunction

  task automatic compare_all(bit en);
    for (int k = 0; k < NI; k++) begin
      chk(tag_of(k, en), du[k], mu[k]);
      chk(tag_of(k, en), dv[k], mv[k]);
      // w of the -90 frame uses a negative product: R6
      chk((k == 2 && en) ? "R6 neg product w" : tag_of(k, en), dw[k], mw[k]);
    end
  endtask

  task automatic cyc(bit en);
    step_en = en;
    @(negedge clk);
    if (en) for (int k = 0; k < NI; k++) model_step(k);
    compare_all(en);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    q_t w_prev;
    model_reset();
    step_en = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      chk("R1 reset", du[k], IU[k]); chk("R1 reset", dv[k], IV[k]); chk("R1 reset", dw[k], IW[k]);
    end
    step_en = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    compare_all(1'b0);

    // R7: first enabled edge moves the state by one step
    w_prev = dw[0];
    cyc(1'b1);
    checks++;
    if (dw[0] === w_prev) begin
      failures++;
      $display("FAIL R7 step got=%0d exp!=%0d", dw[0], w_prev);
    end

    for (int i = 0; i < VEC_N; i++)
      for (int j = 0; j < VEC_LEN[i]; j++) cyc(VEC_EN[i]);

    // R9: trajectories stay bounded
    for (int k = 0; k < NI; k++) begin
      checks++;
      if (du[k] >= (q_t'(128) <<< FR) || du[k] <= -(q_t'(128) <<< FR) ||
          dv[k] >= (q_t'(128) <<< FR) || dv[k] <= -(q_t'(128) <<< FR) ||
          dw[k] >= (q_t'(128) <<< FR) || dw[k] <= -(q_t'(128) <<< FR)) begin
        failures++;
        $display("FAIL R9 bound got=%0d/%0d/%0d exp=|x|<128.0", du[k], dv[k], dw[k]);
      end
    end

    // R8: origin instance keeps u=v=0 and w has decayed
    chk("R8 origin u", du[3], 0);
    chk("R8 origin v", dv[3], 0);
    checks++;
    if (dw[3] >= IW[3]) begin
      failures++;
      $display("FAIL R8 decay got=%0d exp<%0d", dw[3], IW[3]);
    end

    // R1: asynchronous reset mid-run, with enable high
    step_en = 1'b1;
    rst_ni = 1'b0;
    #1;
    model_reset();
    for (int k = 0; k < NI; k++) begin
      chk("R1 async reset", du[k], IU[k]); chk("R1 async reset", dv[k], IV[k]);
      chk("R1 async reset", dw[k], IW[k]);
    end
    repeat (2) @(negedge clk);
    compare_all(1'b0);
    rst_ni = 1'b1;
    for (int j = 0; j < 50; j++) cyc(1'b1);
    cyc(1'b0);
    cyc(1'b1);

    finish_run();
  end
endmodule